// File: doc/BRIEF.md
# Dual-Channel Synthesizer Counter Core

This block is the digital heart of a two-loop frequency synthesizer with an intermediate-frequency (IF) loop and a radio-frequency (RF) loop. It holds the mode and power settings taken from a parallel control word. It runs one reference divider that both loops share and one programmable feedback divider per loop. A phase/frequency comparator per loop turns the divided edges into pump-up and pump-down requests, with an enable that stands in for the high-impedance control of the charge pump. Each loop also has a lock flag, and one multiplexed monitor pin shows the lock state, a divider output or nothing.

All logic runs on one system clock. The reference edge and the two prescaled VCO edges arrive as single-cycle strobes that are already synchronized. Each divider emits a one-cycle terminal pulse, and it emits that pulse on the first strobe after a reset. The comparator measures the gap between the reference pulse and the feedback pulse in reference strobes. A loop is locked after `LOCK_N` consecutive comparisons whose gap is at most `LOCK_WIN` strobes.

Top module: `dsyn_core`

## Requirements
- R1: When `ld_stb` is high, `ld_sel` chooses the target: 00 IF mode, 01 RF mode, 10 IF power, 11 RF power. The other three targets keep their values.
- R2: Power word bit 0 is the modulus select, and it appears directly on `if_mod`/`rf_mod` (0 gives 8/9 for IF and 64/65 for RF; 1 gives 16/17 and 128/129).
- R3: Mode word bit 1 set forces that loop's enable low and its up/down outputs low. After reset all settings are 0 and both enables are high.
- R4: Mode word bit 0 is polarity. With 1 (positive), `up` follows a pending reference edge and `dn` a pending feedback edge. With 0 the two are swapped. `up` and `dn` are never both high.
- R5: Power word bit 1 set stops that loop's feedback divider, clears its comparator and lock, and drops its enable.
- R6: The shared reference divider keeps counting while either loop is powered up, and holds its count only when both loops are powered down.
- R7: Control words are accepted and take effect in every powerdown state.
- R8: The pin code is {RF ld, IF ld, RF fo, IF fo}, from mode word bits 2 (ld) and 3 (fo). 0000 drives the pin low. 0100, 1000 and 1100 show IF lock, RF lock and the AND of both locks; the pin goes low for the cycle of each comparison.
- R9: Codes x001 and x010 show the IF and RF reference pulses (the latter gated by that loop's power). Codes x101 and x110 show the IF and RF feedback divider pulses.
- R10: Codes 0011, 0111 and 1011 drive the pin low and change no counter or lock state.
- R11: Code 1111 holds every divider at zero and clears both comparators and locks. After release, every divider produces its terminal pulse on its first strobe, so the loops restart aligned with the reference.
- R12: A loop's lock sets after `LOCK_N` consecutive in-window comparisons and clears on the first comparison outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_stb | input | 1 | Latch `ld_word` into the target chosen by `ld_sel` |
| ld_sel | input | 2 | Control target select |
| ld_word | input | 4 | Mode word {fo, ld, hiz, pol} or power word {-, -, pd, mod} |
| r_div | input | DIV_W | Reference divide ratio |
| if_ndiv | input | DIV_W | IF feedback divide ratio |
| rf_ndiv | input | DIV_W | RF feedback divide ratio |
| ref_stb | input | 1 | Reference clock edge strobe |
| if_stb | input | 1 | IF prescaler output edge strobe |
| rf_stb | input | 1 | RF prescaler output edge strobe |
| if_up | output | 1 | IF pump-up request |
| if_dn | output | 1 | IF pump-down request |
| if_en | output | 1 | IF pump drive enable (low = high impedance) |
| if_lock | output | 1 | IF lock flag |
| if_mod | output | 1 | IF prescaler modulus select |
| rf_up | output | 1 | RF pump-up request |
| rf_dn | output | 1 | RF pump-down request |
| rf_en | output | 1 | RF pump drive enable (low = high impedance) |
| rf_lock | output | 1 | RF lock flag |
| rf_mod | output | 1 | RF prescaler modulus select |
| test_out | output | 1 | Multiplexed lock / divider monitor pin |

## Verification
The hardest state to reach from the ports is a halted reference divider, because no port shows the reference count directly. The stimulus uses a counter reset to bring every divider to a known zero count. It then powers both loops down, applies two reference strobes, powers one loop up and applies a single strobe. A pulse on the RF reference monitor code proves the count did not move. A second hard case is showing that a counter reset really holds the feedback divider. The bench feeds feedback strobes during the reset to offset it by half a period, and then requires lock after release, which an offset divider can never reach.

// File: rtl/dsyn_pkg.sv
package dsyn_pkg;
    localparam int NCH   = 2;
    localparam int CH_IF = 0;
    localparam int CH_RF = 1;

    // Mode word layout {fo, ld, hiz, pol}
    typedef struct packed {
        logic fo;
        logic ld;
        logic hiz;
        logic pol;
    } mode_t;

    // Power word layout {pd, mod}
    typedef struct packed {
        logic pd;
        logic mod;
    } pwr_t;

    typedef enum logic [1:0] {
        SEL_IF_MODE = 2'b00,
        SEL_RF_MODE = 2'b01,
        SEL_IF_PWR  = 2'b10,
        SEL_RF_PWR  = 2'b11
    } sel_e;
endpackage

// File: rtl/dsyn_div.sv
module dsyn_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic         stb,
    input  logic [W-1:0] div,
    output logic         tc
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run && stb) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = div - 1'b1;
                st_d.tc  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc = st_q.tc;

    // R5 / R6: a stopped divider holds its count
    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(st_q.cnt));

    // R11: counter reset leaves the divider at zero with no pulse
    p_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && !st_q.tc));
endmodule

// File: rtl/dsyn_pfd.sv
module dsyn_pfd #(
    parameter int LOCK_WIN = 1,
    parameter int LOCK_N   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic r_ev,
    input  logic n_ev,
    input  logic ref_stb,
    input  logic pol,
    input  logic hiz,
    input  logic pd,
    output logic up,
    output logic dn,
    output logic en,
    output logic lock,
    output logic cmp
);
    localparam int WIN_W = $clog2(LOCK_WIN + 2);
    localparam int GW    = $clog2(LOCK_N + 1);

    typedef struct packed {
        logic             ref_f;
        logic             vco_f;
        logic [WIN_W-1:0] win;
        logic [GW-1:0]    good;
        logic             lock;
    } st_t;

    st_t  st_d, st_q;
    logic cmp_c, hit_c, in_win;

    assign in_win = (st_q.win <= WIN_W'(LOCK_WIN));

    always_comb begin
        st_d  = st_q;
        cmp_c = 1'b0;
        hit_c = 1'b0;
        if (clr) begin
            st_d = '0;
        end else begin
            if (ref_stb && (st_q.ref_f || st_q.vco_f) && st_q.win != '1)
                st_d.win = st_q.win + 1'b1;
            if (r_ev && n_ev) begin
                cmp_c      = 1'b1;
                hit_c      = !(st_q.ref_f || st_q.vco_f);
                st_d.ref_f = 1'b0;
                st_d.vco_f = 1'b0;
                st_d.win   = '0;
            end else if (r_ev) begin
                if (st_q.vco_f) begin
                    cmp_c      = 1'b1;
                    hit_c      = in_win;
                    st_d.vco_f = 1'b0;
                    st_d.win   = '0;
                end else if (st_q.ref_f) begin
                    cmp_c    = 1'b1;
                    st_d.win = '0;
                end else begin
                    st_d.ref_f = 1'b1;
                    st_d.win   = '0;
                end
            end else if (n_ev) begin
                if (st_q.ref_f) begin
                    cmp_c      = 1'b1;
                    hit_c      = in_win;
                    st_d.ref_f = 1'b0;
                    st_d.win   = '0;
                end else if (st_q.vco_f) begin
                    cmp_c    = 1'b1;
                    st_d.win = '0;
                end else begin
                    st_d.vco_f = 1'b1;
                    st_d.win   = '0;
                end
            end
            if (cmp_c) begin
                if (hit_c) begin
                    if (st_q.good < GW'(LOCK_N)) st_d.good = st_q.good + 1'b1;
                    st_d.lock = (st_d.good >= GW'(LOCK_N));
                end else begin
                    st_d.good = '0;
                    st_d.lock = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = !pd && !hiz;
    assign up   = en && (pol ? st_q.ref_f : st_q.vco_f);
    assign dn   = en && (pol ? st_q.vco_f : st_q.ref_f);
    assign lock = st_q.lock;
    assign cmp  = cmp_c && !clr;

    // R4: never pump both ways at once
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn));

    // R5: a powered-down loop drives nothing
    p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> (!en && !up && !dn));

    // R12: a missed comparison drops lock on the next cycle
    p_miss_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_c && !hit_c && !clr) |=> !lock);

    // R11: reset of the counters clears lock
    p_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!lock && !up && !dn));
endmodule

// File: rtl/dsyn_core.sv
module dsyn_core
    import dsyn_pkg::*;
#(
    parameter int DIV_W    = 12,
    parameter int LOCK_WIN = 1,
    parameter int LOCK_N   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_stb,
    input  logic [1:0]       ld_sel,
    input  logic [3:0]       ld_word,
    input  logic [DIV_W-1:0] r_div,
    input  logic [DIV_W-1:0] if_ndiv,
    input  logic [DIV_W-1:0] rf_ndiv,
    input  logic             ref_stb,
    input  logic             if_stb,
    input  logic             rf_stb,
    output logic             if_up,
    output logic             if_dn,
    output logic             if_en,
    output logic             if_lock,
    output logic             if_mod,
    output logic             rf_up,
    output logic             rf_dn,
    output logic             rf_en,
    output logic             rf_lock,
    output logic             rf_mod,
    output logic             test_out
);
    typedef struct packed {
        mode_t [NCH-1:0] mode;
        pwr_t  [NCH-1:0] pwr;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NCH-1:0]            vco_stb, n_tc, r_ev, up, dn, en, lock, cmp;
    logic [NCH-1:0][DIV_W-1:0] ndiv;
    logic [3:0]                pin_code;
    logic                      cnt_rst, r_tc, r_run, pin;

    always_comb begin
        st_d = st_q;
        if (ld_stb) begin
            unique case (sel_e'(ld_sel))
                SEL_IF_MODE: st_d.mode[CH_IF] = mode_t'(ld_word);
                SEL_RF_MODE: st_d.mode[CH_RF] = mode_t'(ld_word);
                SEL_IF_PWR:  st_d.pwr[CH_IF]  = pwr_t'(ld_word[1:0]);
                SEL_RF_PWR:  st_d.pwr[CH_RF]  = pwr_t'(ld_word[1:0]);
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_code = {st_q.mode[CH_RF].ld, st_q.mode[CH_IF].ld,
                       st_q.mode[CH_RF].fo, st_q.mode[CH_IF].fo};
    assign cnt_rst  = &pin_code;
    assign r_run    = !(st_q.pwr[CH_IF].pd && st_q.pwr[CH_RF].pd);

    assign vco_stb      = {rf_stb, if_stb};
    assign ndiv[CH_IF]  = if_ndiv;
    assign ndiv[CH_RF]  = rf_ndiv;

    dsyn_div #(.W(DIV_W)) u_rdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_run),
        .clr   (cnt_rst),
        .stb   (ref_stb),
        .div   (r_div),
        .tc    (r_tc)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsyn_div #(.W(DIV_W)) u_ndiv (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (!st_q.pwr[c].pd),
            .clr   (cnt_rst),
            .stb   (vco_stb[c]),
            .div   (ndiv[c]),
            .tc    (n_tc[c])
        );

        assign r_ev[c] = r_tc && !st_q.pwr[c].pd;

        dsyn_pfd #(.LOCK_WIN(LOCK_WIN), .LOCK_N(LOCK_N)) u_pfd (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cnt_rst || st_q.pwr[c].pd),
            .r_ev    (r_ev[c]),
            .n_ev    (n_tc[c]),
            .ref_stb (ref_stb),
            .pol     (st_q.mode[c].pol),
            .hiz     (st_q.mode[c].hiz),
            .pd      (st_q.pwr[c].pd),
            .up      (up[c]),
            .dn      (dn[c]),
            .en      (en[c]),
            .lock    (lock[c]),
            .cmp     (cmp[c])
        );
    end

    always_comb begin
        pin = 1'b0;
        unique case (pin_code[1:0])
            2'b00: begin
                unique case (pin_code[3:2])
                    2'b01:   pin = lock[CH_IF] && !cmp[CH_IF];
                    2'b10:   pin = lock[CH_RF] && !cmp[CH_RF];
                    2'b11:   pin = (&lock) && !(|cmp);
                    default: pin = 1'b0;
                endcase
            end
            2'b01:   pin = pin_code[2] ? n_tc[CH_IF] : r_ev[CH_IF];
            2'b10:   pin = pin_code[2] ? n_tc[CH_RF] : r_ev[CH_RF];
            default: pin = 1'b0;
        endcase
    end

    assign test_out = pin;
    assign if_up    = up[CH_IF];
    assign if_dn    = dn[CH_IF];
    assign if_en    = en[CH_IF];
    assign if_lock  = lock[CH_IF];
    assign if_mod   = st_q.pwr[CH_IF].mod;
    assign rf_up    = up[CH_RF];
    assign rf_dn    = dn[CH_RF];
    assign rf_en    = en[CH_RF];
    assign rf_lock  = lock[CH_RF];
    assign rf_mod   = st_q.pwr[CH_RF].mod;

    // R8: disabled code keeps the pin low
    p_pin_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_code == 4'b0000) |-> !test_out);

    // R10: reserved codes keep the pin low
    p_rsv_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_code[1:0] == 2'b11 && pin_code[3:2] != 2'b11) |-> !test_out);

    // R7: a power word is taken even while both loops are down
    p_ld_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && ld_sel == 2'b10 && !r_run) |=> (if_mod == $past(ld_word[0])));

    // R3: high-impedance bit drops the enable
    p_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode[CH_IF].hiz |-> !if_en);
endmodule

// File: tb/dsyn_core_bench.sv
`timescale 1ns/1ps
module dsyn_core_bench;
    localparam int W = 12;

    localparam int S_PIN = 0, S_IFL = 1, S_RFL = 2, S_IFEN = 3, S_RFEN = 4,
                   S_IFUP = 5, S_IFDN = 6, S_IFMOD = 7, S_RFMOD = 8, S_PULSE = 9;

    typedef struct {
        int    id;
        int    exp;
        string tag;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ld_stb = 1'b0;
    logic [1:0] ld_sel = '0;
    logic [3:0] ld_word = '0;
    logic [W-1:0] r_div = 12'd4, if_ndiv = 12'd4, rf_ndiv = 12'd4;
    logic ref_stb = 1'b0, if_stb = 1'b0, rf_stb = 1'b0;
    logic if_up, if_dn, if_en, if_lock, if_mod;
    logic rf_up, rf_dn, rf_en, rf_lock, rf_mod, test_out;

    item_t q[$];
    int    n_chk = 0, n_bad = 0, pulses = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    dsyn_core u_dsyn_core (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_sel(ld_sel), .ld_word(ld_word),
        .r_div(r_div), .if_ndiv(if_ndiv), .rf_ndiv(rf_ndiv),
        .ref_stb(ref_stb), .if_stb(if_stb), .rf_stb(rf_stb),
        .if_up(if_up), .if_dn(if_dn), .if_en(if_en), .if_lock(if_lock), .if_mod(if_mod),
        .rf_up(rf_up), .rf_dn(rf_dn), .rf_en(rf_en), .rf_lock(rf_lock), .rf_mod(rf_mod),
        .test_out(test_out)
    );

    function automatic int observe(int id);
        case (id)
            S_PIN:   return int'(test_out);
            S_IFL:   return int'(if_lock);
            S_RFL:   return int'(rf_lock);
            S_IFEN:  return int'(if_en);
            S_RFEN:  return int'(rf_en);
            S_IFUP:  return int'(if_up);
            S_IFDN:  return int'(if_dn);
            S_IFMOD: return int'(if_mod);
            S_RFMOD: return int'(rf_mod);
            default: return pulses;
        endcase
    endfunction

    // monitor: pops expected items and compares against the design
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int    act;
            it  = q.pop_front();
            act = observe(it.id);
            n_chk++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
            end
        end
        if (test_out) pulses++;
    end

    task automatic expect_val(int id, int exp, string tag);
        item_t it;
        @(posedge clk); #1;
        it.id = id; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic load(logic [1:0] sel, logic [3:0] word);
        @(negedge clk);
        ld_stb = 1'b1; ld_sel = sel; ld_word = word;
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic tick(int n, bit r, bit i, bit f);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ref_stb = r; if_stb = i; rf_stb = f;
            @(negedge clk);
            ref_stb = 1'b0; if_stb = 1'b0; rf_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clr_pulses();
        @(posedge clk); #1;
        pulses = 0;
    endtask

    // counter reset with an offset injected on the IF feedback path, then release
    task automatic realign();
        load(2'b00, 4'b1100);
        load(2'b01, 4'b1100);
        expect_val(S_IFL, 0, "R11 locks cleared in counter reset");
        expect_val(S_PIN, 0, "R11 pin low in counter reset");
        tick(2, 1'b1, 1'b1, 1'b1);
        tick(2, 1'b0, 1'b1, 1'b0);
        load(2'b00, 4'b0100);
        load(2'b01, 4'b0100);
        tick(16, 1'b1, 1'b1, 1'b1);
        expect_val(S_IFL, 1, "R11 IF relocks after release");
        expect_val(S_RFL, 1, "R11 RF relocks after release");
        expect_val(S_PIN, 1, "R8 combined lock on pin");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        expect_val(S_PIN, 0, "R8 pin low after reset");
        expect_val(S_IFL, 0, "R12 unlocked after reset");
        expect_val(S_IFEN, 1, "R3 enable high after reset");
        expect_val(S_IFMOD, 0, "R2 IF modulus after reset");

        load(2'b10, 4'b0001);
        expect_val(S_IFMOD, 1, "R2 IF modulus 16/17");
        expect_val(S_RFMOD, 0, "R1 RF power untouched");
        load(2'b11, 4'b0001);
        expect_val(S_RFMOD, 1, "R2 RF modulus 128/129");

        load(2'b00, 4'b0010);
        expect_val(S_IFEN, 0, "R3 IF high impedance");
        expect_val(S_RFEN, 1, "R1 RF mode untouched");
        load(2'b00, 4'b0000);
        expect_val(S_IFEN, 1, "R3 IF enable restored");

        load(2'b00, 4'b0100);
        load(2'b01, 4'b0100);
        tick(20, 1'b1, 1'b1, 1'b1);
        expect_val(S_IFL, 1, "R12 IF locks on aligned edges");
        expect_val(S_RFL, 1, "R12 RF locks on aligned edges");
        expect_val(S_PIN, 1, "R8 combined lock high");
        load(2'b01, 4'b0000);
        expect_val(S_PIN, 1, "R8 IF lock code");
        load(2'b00, 4'b0000);
        load(2'b01, 4'b0100);
        expect_val(S_PIN, 1, "R8 RF lock code");

        load(2'b01, 4'b0000);
        load(2'b00, 4'b1000);
        clr_pulses();
        tick(8, 1'b1, 1'b1, 1'b1);
        expect_val(S_PULSE, 2, "R9 IF reference pulses");

        load(2'b00, 4'b1100);
        clr_pulses();
        tick(8, 1'b0, 1'b1, 1'b0);
        expect_val(S_PULSE, 2, "R9 IF feedback pulses");
        expect_val(S_IFL, 0, "R12 IF drops on miss");
        expect_val(S_RFL, 1, "R12 RF keeps lock");

        load(2'b00, 4'b0000);
        expect_val(S_IFUP, 1, "R4 negative polarity up");
        expect_val(S_IFDN, 0, "R4 negative polarity dn");
        load(2'b00, 4'b0001);
        expect_val(S_IFUP, 0, "R4 positive polarity up");
        expect_val(S_IFDN, 1, "R4 positive polarity dn");

        realign();

        load(2'b10, 4'b0011);
        expect_val(S_IFEN, 0, "R5 IF enable off in powerdown");
        expect_val(S_IFL, 0, "R5 IF lock cleared in powerdown");
        expect_val(S_RFL, 1, "R5 RF unaffected");
        load(2'b00, 4'b1100);
        load(2'b01, 4'b0000);
        clr_pulses();
        tick(8, 1'b0, 1'b1, 1'b0);
        expect_val(S_PULSE, 0, "R5 IF feedback divider stopped");

        load(2'b00, 4'b0000);
        load(2'b01, 4'b1000);
        clr_pulses();
        tick(8, 1'b1, 1'b0, 1'b0);
        expect_val(S_PULSE, 2, "R6 reference runs with one loop up");

        load(2'b11, 4'b0011);
        load(2'b10, 4'b0010);
        expect_val(S_IFMOD, 0, "R7 word accepted with both loops down");
        tick(2, 1'b1, 1'b0, 1'b0);
        load(2'b11, 4'b0001);
        clr_pulses();
        tick(1, 1'b1, 1'b0, 1'b0);
        expect_val(S_PULSE, 1, "R6 reference held with both loops down");

        load(2'b10, 4'b0001);
        load(2'b00, 4'b0000);
        realign();
        load(2'b00, 4'b1000);
        load(2'b01, 4'b1000);
        clr_pulses();
        tick(8, 1'b1, 1'b1, 1'b1);
        expect_val(S_PULSE, 0, "R10 reserved code pin low");
        expect_val(S_IFL, 1, "R10 reserved code keeps IF lock");
        expect_val(S_RFL, 1, "R10 reserved code keeps RF lock");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule